// File: doc/BRIEF.md
# Decode-Stage Skid Flow Controller

This block controls the flow of instructions for one thread through a decode pipeline stage. Each cycle it takes up to `IN_W` instructions from the fetch queue and sends up to `OUT_W` of them on to the rename queue. It keeps one sticky stall flag for each of three downstream sources: rename, execute and commit. When any flag is set, or when more live instructions arrive than fit in the output, the excess goes into a skid FIFO. The controller then tells fetch to hold off.

Once the stalls clear, the stage enters a separate draining phase. In this phase it sends from the skid FIFO and appends any fresh arrivals behind the parked ones. It releases fetch only when the FIFO has gone empty. A commit-side squash flushes everything and overrides all other conditions. An indication that the reorder buffer is still squashing holds the stage quiet.

All outputs are registered. The inputs sampled at one clock edge are reflected at the ports just after that edge.

Top module: `dsc_top`

## Requirements
- R1: After reset, `state` is Idle, no stall flag is set, `out_cnt`, `skid_level`, `fetch_block`, `fetch_unblock` and `skid_ovf` are all 0. The state codes are: Idle=0, Running=1, Blocked=2, Unblocking=3, Squashing=4.
- R2: In Idle or Running with no stall, the live inputs are forwarded in arrival order, packed from slot 0. The number forwarded is min(live, `OUT_W`). Live inputs are the first `in_cnt` entries whose `in_kill` bit is 0. Killed entries use no output slot.
- R3: If live inputs remain after `OUT_W` are forwarded, the remainder enters the skid FIFO. The state becomes Blocked and `fetch_block` pulses for one cycle.
- R4: Each stall flag is sticky. `stall_set[k]` sets it and `stall_clr[k]` clears it (bit 0 rename, 1 execute, 2 commit). While any flag is set, nothing is forwarded and all live inputs are appended to the skid FIFO. `fetch_block` pulses only when the state was not already Blocked.
- R5: The first stall-free cycle in Blocked moves the state to Unblocking. In Unblocking, up to `OUT_W` of the oldest skid entries are forwarded. Live fresh inputs in the same cycle are appended behind the remaining entries.
- R6: `fetch_unblock` pulses and the state becomes Running only in the cycle the skid FIFO ends empty. Otherwise the state stays Unblocking.
- R7: `cmt_squash` takes priority over everything else. It empties the skid FIFO, discards the inputs, forwards nothing and sets the state to Squashing. It pulses `fetch_unblock` if the state was Blocked or Unblocking.
- R8: When `rob_squashing` is set without `cmt_squash`, the state is Squashing, nothing is forwarded and the inputs are discarded. The first later cycle with neither squash input nor any stall moves the state to Running and forwards that cycle's inputs.
- R9: The skid FIFO holds `LAT*IN_W+OUT_W` entries. Entries beyond capacity are dropped, and `skid_ovf` is set and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_cnt | input | $clog2(IN_W+1) | Number of occupied input entries |
| in_insn | input | IN_W*DW | Input instruction entries, slot 0 oldest |
| in_kill | input | IN_W | Per-entry already-squashed mark |
| stall_set | input | 3 | Stall assert pulse per downstream source |
| stall_clr | input | 3 | Stall release pulse per downstream source |
| cmt_squash | input | 1 | Squash from commit |
| rob_squashing | input | 1 | Reorder buffer still squashing |
| out_cnt | output | $clog2(OUT_W+1) | Number of valid output slots |
| out_insn | output | OUT_W*DW | Forwarded entries, packed from slot 0 |
| fetch_block | output | 1 | One-cycle request for fetch to stop |
| fetch_unblock | output | 1 | One-cycle release for fetch |
| state | output | 3 | Current status code |
| skid_level | output | $clog2(LAT*IN_W+OUT_W+1) | Skid FIFO occupancy |
| skid_ovf | output | 1 | Sticky skid overflow flag |

## Verification
Faults in the status register or the skid FIFO pointers show at the ports right after the edge that samples the trigger. A lost entry appears as a missing or reordered instruction in `out_insn` during the drain. A wrong level appears in `skid_level` at once, and an early release appears as a `fetch_unblock` pulse while entries remain. The drain test follows a seven-entry backlog slot by slot over five cycles, so an error in head advance or wrap is visible within one cycle of when it happens. Priority faults show on the edge where the squash, the stall and the Blocked exit coincide, as a wrong state code or a spurious pulse.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_RUN        = 3'd1,
        ST_BLOCKED    = 3'd2,
        ST_UNBLOCKING = 3'd3,
        ST_SQUASHING  = 3'd4
    } dsc_state_e;

    localparam int N_STALL_SRC = 3;
    localparam int SRC_RENAME  = 0;
    localparam int SRC_EXEC    = 1;
    localparam int SRC_COMMIT  = 2;

    function automatic int min_i(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/dsc_compact.sv
module dsc_compact #(
    parameter int IN_W = 4,
    parameter int DW   = 16,
    parameter int CW   = $clog2(IN_W + 1)
) (
    input  logic [CW-1:0]            cnt,
    input  logic [IN_W-1:0][DW-1:0]  data,
    input  logic [IN_W-1:0]          kill,
    output logic [IN_W-1:0][DW-1:0]  live,
    output logic [CW-1:0]            live_n
);
    always_comb begin
        int n;
        n    = 0;
        live = '0;
        for (int i = 0; i < IN_W; i++) begin
            if (i < int'(cnt) && !kill[i]) begin
                live[n] = data[i];
                n       = n + 1;
            end
        end
        live_n = CW'(n);
    end
endmodule

// File: rtl/dsc_stall_track.sv
module dsc_stall_track
    import dsc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_STALL_SRC-1:0] set_i,
    input  logic [N_STALL_SRC-1:0] clr_i,
    output logic [N_STALL_SRC-1:0] flags_nxt
);
    logic [N_STALL_SRC-1:0] flags_q;

    assign flags_nxt = (flags_q | set_i) & ~clr_i;

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_nxt;
    end

    for (genvar k = 0; k < N_STALL_SRC; k++) begin : g_chk
        // R4: a release must follow an earlier assert from the same source
        a_r4_no_orphan_release: assert property (@(posedge clk) disable iff (rst)
            clr_i[k] |-> (flags_q[k] || set_i[k]));
    end
endmodule

// File: rtl/dsc_skid_fifo.sv
module dsc_skid_fifo #(
    parameter int DEPTH = 10,
    parameter int IN_W  = 4,
    parameter int OUT_W = 2,
    parameter int DW    = 16,
    localparam int ICW  = $clog2(IN_W + 1),
    localparam int OCW  = $clog2(OUT_W + 1),
    localparam int LVW  = $clog2(DEPTH + 1),
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     flush,
    input  logic [OCW-1:0]           pop_n,
    input  logic [ICW-1:0]           push_n,
    input  logic [IN_W-1:0][DW-1:0]  push_data,
    output logic [OUT_W-1:0][DW-1:0] peek,
    output logic [LVW-1:0]           level,
    output logic                     ovf
);
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] rd_q;
    logic [LVW-1:0] cnt_q;
    int free_n, acc_n;

    always_comb begin
        free_n = DEPTH - int'(cnt_q) + int'(pop_n);
        acc_n  = dsc_pkg::min_i(int'(push_n), free_n);
        ovf    = !flush && (int'(push_n) > free_n);
        for (int i = 0; i < OUT_W; i++)
            peek[i] = mem[(int'(rd_q) + i) % DEPTH];
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            for (int i = 0; i < IN_W; i++)
                if (i < acc_n)
                    mem[(int'(rd_q) + int'(cnt_q) + i) % DEPTH] <= push_data[i];
            rd_q  <= PW'((int'(rd_q) + int'(pop_n)) % DEPTH);
            cnt_q <= LVW'(int'(cnt_q) - int'(pop_n) + acc_n);
        end
    end

    assign level = cnt_q;

    a_r9_level_bound: assert property (@(posedge clk) disable iff (rst)
        int'(cnt_q) <= DEPTH);
    a_r5_pop_within_level: assert property (@(posedge clk) disable iff (rst)
        pop_n <= OCW'(cnt_q > LVW'(OUT_W) ? LVW'(OUT_W) : cnt_q));
endmodule

// File: rtl/dsc_top.sv
module dsc_top
    import dsc_pkg::*;
#(
    parameter int IN_W  = 4,
    parameter int OUT_W = 2,
    parameter int LAT   = 2,
    parameter int DW    = 16,
    localparam int DEPTH = LAT * IN_W + OUT_W,
    localparam int ICW   = $clog2(IN_W + 1),
    localparam int OCW   = $clog2(OUT_W + 1),
    localparam int LVW   = $clog2(DEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ICW-1:0]           in_cnt,
    input  logic [IN_W-1:0][DW-1:0]  in_insn,
    input  logic [IN_W-1:0]          in_kill,
    input  logic [2:0]               stall_set,
    input  logic [2:0]               stall_clr,
    input  logic                     cmt_squash,
    input  logic                     rob_squashing,
    output logic [OCW-1:0]           out_cnt,
    output logic [OUT_W-1:0][DW-1:0] out_insn,
    output logic                     fetch_block,
    output logic                     fetch_unblock,
    output logic [2:0]               state,
    output logic [LVW-1:0]           skid_level,
    output logic                     skid_ovf
);
    logic [IN_W-1:0][DW-1:0]  live;
    logic [ICW-1:0]           live_n;
    logic [N_STALL_SRC-1:0]   flags_nxt;
    logic [OUT_W-1:0][DW-1:0] peek;
    logic [LVW-1:0]           level;
    logic                     ovf;

    dsc_state_e st_q, st_n;
    logic [OCW-1:0]           out_cnt_q, out_n;
    logic [OUT_W-1:0][DW-1:0] out_q, out_d;
    logic blk_q, blk_n, unblk_q, unblk_n, err_q, flush;
    logic [OCW-1:0]           pop_n;
    logic [ICW-1:0]           push_n;
    logic [IN_W-1:0][DW-1:0]  push_data;

    dsc_compact #(.IN_W(IN_W), .DW(DW), .CW(ICW)) u_compact (
        .cnt(in_cnt), .data(in_insn), .kill(in_kill),
        .live(live), .live_n(live_n)
    );

    dsc_stall_track u_stall (
        .clk(clk), .rst(rst), .set_i(stall_set), .clr_i(stall_clr),
        .flags_nxt(flags_nxt)
    );

    dsc_skid_fifo #(.DEPTH(DEPTH), .IN_W(IN_W), .OUT_W(OUT_W), .DW(DW)) u_skid (
        .clk(clk), .rst(rst), .flush(flush), .pop_n(pop_n), .push_n(push_n),
        .push_data(push_data), .peek(peek), .level(level), .ovf(ovf)
    );

    always_comb begin
        logic mode_run, mode_unb;
        int   off, send, pop;
        st_n     = st_q;
        out_n    = '0;
        out_d    = '0;
        blk_n    = 1'b0;
        unblk_n  = 1'b0;
        flush    = 1'b0;
        pop_n    = '0;
        push_n   = '0;
        off      = 0;
        send     = 0;
        pop      = 0;
        mode_run = 1'b0;
        mode_unb = 1'b0;

        // priority chain: commit squash, rob squash, stall, blocked exit, squash exit
        if (cmt_squash) begin
            flush   = 1'b1;
            st_n    = ST_SQUASHING;
            unblk_n = (st_q == ST_BLOCKED) || (st_q == ST_UNBLOCKING);
        end else if (rob_squashing) begin
            st_n = ST_SQUASHING;
        end else if (|flags_nxt) begin
            push_n = live_n;
            st_n   = ST_BLOCKED;
            blk_n  = (st_q != ST_BLOCKED);
        end else if (st_q == ST_BLOCKED || st_q == ST_UNBLOCKING) begin
            mode_unb = 1'b1;
        end else begin
            mode_run = 1'b1;
            if (st_q == ST_SQUASHING) st_n = ST_RUN;
        end

        if (mode_run) begin
            send  = min_i(int'(live_n), OUT_W);
            out_n = OCW'(send);
            for (int i = 0; i < OUT_W; i++)
                if (i < IN_W) out_d[i] = live[i];
            off    = send;
            push_n = ICW'(int'(live_n) - send);
            if (int'(live_n) > send) begin
                st_n  = ST_BLOCKED;
                blk_n = 1'b1;
            end
        end

        if (mode_unb) begin
            pop    = min_i(int'(level), OUT_W);
            pop_n  = OCW'(pop);
            out_n  = OCW'(pop);
            for (int i = 0; i < OUT_W; i++)
                if (i < pop) out_d[i] = peek[i];
            push_n = live_n;
            if (int'(level) - pop + int'(live_n) == 0) begin
                unblk_n = 1'b1;
                st_n    = ST_RUN;
            end else begin
                st_n = ST_UNBLOCKING;
            end
        end

        push_data = '0;
        for (int i = 0; i < IN_W; i++)
            if (off + i < IN_W) push_data[i] = live[off + i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            out_cnt_q <= '0;
            out_q     <= '0;
            blk_q     <= 1'b0;
            unblk_q   <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            st_q      <= st_n;
            out_cnt_q <= out_n;
            out_q     <= out_d;
            blk_q     <= blk_n;
            unblk_q   <= unblk_n;
            err_q     <= err_q | ovf;
        end
    end

    assign out_cnt       = out_cnt_q;
    assign out_insn      = out_q;
    assign fetch_block   = blk_q;
    assign fetch_unblock = unblk_q;
    assign state         = st_q;
    assign skid_level    = level;
    assign skid_ovf      = err_q;

    a_r2_out_bound: assert property (@(posedge clk) disable iff (rst)
        int'(out_cnt_q) <= OUT_W);
    a_r3_block_pulse_in_blocked: assert property (@(posedge clk) disable iff (rst)
        blk_q |-> st_q == ST_BLOCKED);
    a_r4_stall_holds_output: assert property (@(posedge clk) disable iff (rst)
        (!cmt_squash && !rob_squashing && |flags_nxt) |=> (out_cnt_q == '0 && st_q == ST_BLOCKED));
    a_r6_release_when_empty: assert property (@(posedge clk) disable iff (rst)
        unblk_q |-> level == '0);
    a_r7_squash_clears: assert property (@(posedge clk) disable iff (rst)
        cmt_squash |=> (st_q == ST_SQUASHING && level == '0 && out_cnt_q == '0 && !blk_q));
    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);
endmodule

// File: tb/dsc_top_tb.sv
`timescale 1ns/1ps
module dsc_top_tb;
    localparam int IN_W = 4, OUT_W = 2, LAT = 2, DW = 16;

    logic clk = 1'b0;
    logic rst;
    logic [2:0]              in_cnt;
    logic [IN_W-1:0][DW-1:0] in_insn;
    logic [IN_W-1:0]         in_kill;
    logic [2:0]              stall_set, stall_clr;
    logic                    cmt_squash, rob_squashing;
    logic [1:0]              out_cnt;
    logic [OUT_W-1:0][DW-1:0] out_insn;
    logic                    fetch_block, fetch_unblock, skid_ovf;
    logic [2:0]              state;
    logic [3:0]              skid_level;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dsc_top #(.IN_W(IN_W), .OUT_W(OUT_W), .LAT(LAT), .DW(DW)) u_dut (
        .clk(clk), .rst(rst), .in_cnt(in_cnt), .in_insn(in_insn), .in_kill(in_kill),
        .stall_set(stall_set), .stall_clr(stall_clr), .cmt_squash(cmt_squash),
        .rob_squashing(rob_squashing), .out_cnt(out_cnt), .out_insn(out_insn),
        .fetch_block(fetch_block), .fetch_unblock(fetch_unblock), .state(state),
        .skid_level(skid_level), .skid_ovf(skid_ovf)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic quiet();
        in_cnt = '0; in_insn = '0; in_kill = '0;
        stall_set = '0; stall_clr = '0; cmt_squash = 1'b0; rob_squashing = 1'b0;
    endtask

    task automatic feed(input int cnt, input int base, input logic [3:0] kill);
        in_cnt = 3'(cnt); in_kill = kill;
        for (int i = 0; i < IN_W; i++) in_insn[i] = DW'(base + i);
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic see(input string req, input int st, input int oc,
                       input int d0, input int d1, input int lvl,
                       input int blk, input int unb);
        chk({req, " state"}, int'(state), st);
        chk({req, " out_cnt"}, int'(out_cnt), oc);
        if (oc > 0) chk({req, " slot0"}, int'(out_insn[0]), d0);
        if (oc > 1) chk({req, " slot1"}, int'(out_insn[1]), d1);
        chk({req, " level"}, int'(skid_level), lvl);
        chk({req, " block"}, int'(fetch_block), blk);
        chk({req, " unblock"}, int'(fetch_unblock), unb);
    endtask

    task automatic t_reset();
        quiet(); rst = 1'b1;
        step(); step();
        rst = 1'b0;
        see("R1 reset", 0, 0, 0, 0, 0, 0, 0);
        chk("R1 ovf", int'(skid_ovf), 0);
    endtask

    task automatic t_run();
        quiet(); feed(2, 'h100, 4'b0000); step();
        see("R2 two live", 0, 2, 'h100, 'h101, 0, 0, 0);
        quiet(); feed(3, 'h110, 4'b0001); step();
        see("R2 killed slot skipped", 0, 2, 'h111, 'h112, 0, 0, 0);
        quiet(); feed(4, 'h120, 4'b1010); step();
        see("R2 sparse kill", 0, 2, 'h120, 'h122, 0, 0, 0);
    endtask

    task automatic t_leftover();
        quiet(); feed(4, 'h200, 4'b0000); step();
        see("R3 leftover blocks", 2, 2, 'h200, 'h201, 2, 1, 0);
        quiet(); step();
        see("R6 drain to empty", 1, 2, 'h202, 'h203, 0, 0, 1);
    endtask

    task automatic t_stall_drain();
        quiet(); stall_set = 3'b001; feed(3, 'hA00, 4'b0000); step();
        see("R4 stall parks input", 2, 0, 0, 0, 3, 1, 0);
        quiet(); feed(4, 'hB00, 4'b0000); step();
        see("R4 sticky no second block", 2, 0, 0, 0, 7, 0, 0);
        quiet(); stall_clr = 3'b001; feed(2, 'hC00, 4'b0000); step();
        see("R5 unblocking first", 3, 2, 'hA00, 'hA01, 7, 0, 0);
        quiet(); step();
        see("R5 drain order", 3, 2, 'hA02, 'hB00, 5, 0, 0);
        quiet(); step();
        see("R5 drain middle", 3, 2, 'hB01, 'hB02, 3, 0, 0);
        quiet(); step();
        see("R6 not yet empty", 3, 2, 'hB03, 'hC00, 1, 0, 0);
        quiet(); step();
        see("R6 release at empty", 1, 1, 'hC01, 0, 0, 0, 1);
    endtask

    task automatic t_cmt_squash();
        quiet(); stall_set = 3'b010; feed(4, 'hD00, 4'b0000); step();
        see("R4 exec stall", 2, 0, 0, 0, 4, 1, 0);
        quiet(); cmt_squash = 1'b1; feed(4, 'hD10, 4'b0000); step();
        see("R7 squash over stall", 4, 0, 0, 0, 0, 0, 1);
        quiet(); stall_clr = 3'b010; feed(2, 'hE00, 4'b0000); step();
        see("R8 squash exit forwards", 1, 2, 'hE00, 'hE01, 0, 0, 0);
    endtask

    task automatic t_rob();
        quiet(); rob_squashing = 1'b1; feed(2, 'hF10, 4'b0000); step();
        see("R8 rob squashing quiet", 4, 0, 0, 0, 0, 0, 0);
        quiet(); feed(1, 'hF00, 4'b0000); step();
        see("R8 back to running", 1, 1, 'hF00, 0, 0, 0, 0);
    endtask

    task automatic t_overflow();
        quiet(); stall_set = 3'b100; feed(4, 'h300, 4'b0000); step();
        chk("R9 level 4", int'(skid_level), 4);
        quiet(); feed(4, 'h310, 4'b0000); step();
        chk("R9 level 8", int'(skid_level), 8);
        chk("R9 no ovf yet", int'(skid_ovf), 0);
        quiet(); feed(4, 'h320, 4'b0000); step();
        chk("R9 capped level", int'(skid_level), 10);
        chk("R9 ovf set", int'(skid_ovf), 1);
        quiet(); cmt_squash = 1'b1; stall_clr = 3'b100; step();
        see("R7 squash from blocked", 4, 0, 0, 0, 0, 0, 1);
        quiet(); step();
        chk("R9 ovf sticky", int'(skid_ovf), 1);
        chk("R8 running after squash", int'(state), 1);
    endtask

    initial begin
        t_reset();
        t_run();
        t_leftover();
        t_stall_drain();
        t_cmt_squash();
        t_rob();
        t_overflow();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule